// File: doc/BRIEF.md
# Per-Core Data Cache Coherence Controller

This block holds the tag and coherence state of a small direct-mapped data cache for one core. It works in one of two modes. In copy-back mode a line can be Modified, Exclusive, Shared or Invalid. In write-through mode a line never enters the Modified state, so only Exclusive, Shared and Invalid occur. Local reads and writes that hit complete in the same cycle. Other cases raise exactly one request to a central snoop controller and stall the access until that controller acknowledges: an upgrade of a shared line, a fill on a miss, or the eviction of a dirty victim. The acknowledgement carries the fill data and a flag that says whether another cache also holds the line.

The central controller can also snoop the cache at any time, including while the core is in light sleep. A fill snoop reads the line and demotes it to Shared. An invalidate snoop removes the line and returns its dirty data if it had any. While light sleep is high, no new local request is started and no local access completes. The snoop path keeps working.

Each line holds one data word. A line address has an index part (its low `IW` bits) and a tag part (the remaining bits).

Top module: `coh_line_ctrl`

## Requirements
- R1: In copy-back mode (`wt_mode`=0), a read hit and a write hit on an Exclusive or Modified line complete in the same cycle (`acc_ready`=1) and raise no request. A write hit on Exclusive moves the line to Modified.
- R2: In write-through mode (`wt_mode`=1), no line ever becomes Modified. A write hit on Exclusive stays Exclusive with no request, and an upgrade or a write-miss fill leaves the line Exclusive.
- R3: A write hit on a Shared line raises an invalidate request (`req_type`=0) with the line address. The write completes only on `req_ack`, and the line is then Modified in copy-back mode.
- R4: A read miss raises a fill request (`req_type`=1). On acknowledge, `acc_rdata` equals `ack_data`, and the line becomes Shared if `ack_shared`=1 or Exclusive otherwise.
- R5: A write miss raises a combined fill-and-invalidate request (`req_type`=2). After it is acknowledged, the line holds the written word and is Modified in copy-back mode.
- R6: A miss whose victim line is Modified first raises a write-back request (`req_type`=3) carrying the victim's address and data. The victim is then Invalid, and the miss request follows.
- R7: An invalidate snoop (`snp_type`=1) that hits leaves the line Invalid. When the line was Modified, the response has `snp_dirty`=1 and `snp_data` equal to the dirty word.
- R8: A fill snoop (`snp_type`=0) that hits a Modified or Exclusive line returns its data on `snp_data` and demotes the line to Shared. `snp_dirty`=1 only for Modified.
- R9: While `light_sleep`=1, no request is raised and no local access completes, but snoops are still accepted (`snp_ready`=1) and answered.
- R10: At most one request is outstanding. `req_valid`, `req_type`, `req_addr` and `req_data` hold steady until `req_ack`, and the access stays stalled until then.
- R11: After reset every line is Invalid, `req_valid`=0, and a snoop reports `snp_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_mode | input | 1 | 1 = write-through (E/S/I states), 0 = copy-back (M/E/S/I states) |
| light_sleep | input | 1 | Core asleep: only snoops are served |
| acc_valid | input | 1 | Local access present, held until `acc_ready` |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Line address of the access |
| acc_wdata | input | DW | Write word |
| acc_ready | output | 1 | Access completes at this clock edge |
| acc_rdata | output | DW | Read word, valid with `acc_ready` |
| req_valid | output | 1 | Request to the snoop controller |
| req_type | output | 2 | 0 invalidate, 1 fill, 2 fill+invalidate, 3 write-back |
| req_addr | output | AW | Line address of the request |
| req_data | output | DW | Write-back word |
| req_ack | input | 1 | Controller accepts and completes the request |
| ack_shared | input | 1 | Another sharer exists (fill result) |
| ack_data | input | DW | Fill data |
| snp_valid | input | 1 | Incoming snoop |
| snp_type | input | 1 | 0 fill, 1 invalidate |
| snp_addr | input | AW | Snooped line address |
| snp_ready | output | 1 | Snoop is taken at this edge |
| snp_hit | output | 1 | Snooped line is present |
| snp_dirty | output | 1 | Snooped line was Modified |
| snp_data | output | DW | Data of the snooped line |

## Verification
The bench infers line state from the ports. A write that raises no request shows the line was Exclusive or Modified. An invalidate request shows it was Shared. `snp_dirty` separates Modified from Exclusive. Eviction of a dirty victim is the key case: a design that skipped the write-back or sent it after the fill would lose or reorder the dirty word. Write-through mode is run through upgrade and write-miss paths, where a wrong design would report `snp_dirty`. Light sleep is held with a pending miss and a snoop in the middle; a wrong design would either leak a request or refuse the snoop. A delayed acknowledge checks that the request fields stay stable and the access remains stalled.

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl #(
  parameter int AW = 8,
  parameter int IW = 2,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wt_mode,
  input  logic          light_sleep,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic          acc_ready,
  output logic [DW-1:0] acc_rdata,
  output logic          req_valid,
  output logic [1:0]    req_type,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  input  logic          req_ack,
  input  logic          ack_shared,
  input  logic [DW-1:0] ack_data,
  input  logic          snp_valid,
  input  logic          snp_type,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_ready,
  output logic          snp_hit,
  output logic          snp_dirty,
  output logic [DW-1:0] snp_data
);
  localparam int NL = 1 << IW;
  localparam int TW = AW - IW;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] RQ_INV = 2'd0, RQ_FILL = 2'd1, RQ_FINV = 2'd2, RQ_WB = 2'd3;
  localparam logic SN_INV = 1'b1;

  logic [1:0]    st  [NL];
  logic [TW-1:0] tg  [NL];
  logic [DW-1:0] dat [NL];

  logic [IW-1:0] aidx, sidx, ridx;
  logic [TW-1:0] atag, stag;
  logic          a_hit, ack_now, loc_go, quick, need_req;
  logic [1:0]    dirty_st, new_type;

  assign aidx = acc_addr[IW-1:0];
  assign atag = acc_addr[AW-1:IW];
  assign sidx = snp_addr[IW-1:0];
  assign stag = snp_addr[AW-1:IW];
  assign ridx = req_addr[IW-1:0];

  assign a_hit    = (st[aidx] != ST_I) && (tg[aidx] == atag);
  assign ack_now  = req_valid && req_ack;
  assign loc_go   = !req_valid && acc_valid && !light_sleep && !snp_valid;
  assign quick    = loc_go && a_hit && !(acc_write && st[aidx] == ST_S);
  assign need_req = loc_go && !quick;
  assign dirty_st = wt_mode ? ST_E : ST_M;

  always_comb begin
    if (a_hit)                 new_type = RQ_INV;
    else if (st[aidx] == ST_M) new_type = RQ_WB;
    else if (acc_write)        new_type = RQ_FINV;
    else                       new_type = RQ_FILL;
  end

  assign acc_ready = quick || (ack_now && req_type != RQ_WB);
  assign acc_rdata = ack_now ? ack_data : dat[aidx];

  assign snp_ready = snp_valid && !ack_now;
  assign snp_hit   = (st[sidx] != ST_I) && (tg[sidx] == stag);
  assign snp_dirty = snp_hit && st[sidx] == ST_M;
  assign snp_data  = dat[sidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) st[i] <= ST_I;
      req_valid <= 1'b0;
      req_type  <= RQ_INV;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      if (snp_ready && snp_hit)
        st[sidx] <= (snp_type == SN_INV) ? ST_I : ST_S;
      if (quick && acc_write && st[aidx] == ST_E)
        st[aidx] <= dirty_st;
      if (ack_now) begin
        case (req_type)
          RQ_WB:   st[ridx] <= ST_I;
          RQ_FILL: st[ridx] <= ack_shared ? ST_S : ST_E;
          default: st[ridx] <= dirty_st;
        endcase
        req_valid <= 1'b0;
      end else if (need_req) begin
        req_valid <= 1'b1;
        req_type  <= new_type;
        req_addr  <= (new_type == RQ_WB) ? {tg[aidx], aidx} : acc_addr;
        req_data  <= dat[aidx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (quick && acc_write) dat[aidx] <= acc_wdata;
    if (ack_now) begin
      case (req_type)
        RQ_FILL: begin tg[ridx] <= req_addr[AW-1:IW]; dat[ridx] <= ack_data; end
        RQ_FINV: begin tg[ridx] <= req_addr[AW-1:IW]; dat[ridx] <= acc_wdata; end
        RQ_INV:  dat[ridx] <= acc_wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_chk
    // R2
    wt_no_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wt_mode && $past(wt_mode) && st[g] == ST_M) |-> $past(st[g]) == ST_M);
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_type) && $stable(req_addr) && $stable(req_data)));

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !$past(light_sleep));

  // R7
  snp_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_ready && snp_type == SN_INV && snp_hit) |=> st[$past(sidx)] == ST_I);

  // R8
  snp_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_ready && snp_type != SN_INV && snp_hit) |=> st[$past(sidx)] == ST_S);
endmodule

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wt_mode = 1'b0, light_sleep = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic acc_ready;
  logic [15:0] acc_rdata;
  logic req_valid;
  logic [1:0] req_type;
  logic [7:0] req_addr;
  logic [15:0] req_data;
  logic req_ack = 1'b0, ack_shared = 1'b0;
  logic [15:0] ack_data = '0;
  logic snp_valid = 1'b0, snp_type = 1'b0;
  logic [7:0] snp_addr = '0;
  logic snp_ready, snp_hit, snp_dirty;
  logic [15:0] snp_data;

  int checks = 0, errors = 0;
  int nreq;
  logic [1:0] rq_t [4];
  logic [7:0] rq_a [4];
  logic [15:0] rq_d [4];
  logic [15:0] got_rd;
  logic done, stall_bad;
  logic s_rdy, s_hit, s_dirty;
  logic [15:0] s_data;

  always #10 clk = ~clk;

  coh_line_ctrl i_coh_line_ctrl (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic w, input logic [7:0] a, input logic [15:0] d,
                           input logic sh, input logic [15:0] ad, input int dly);
    nreq = 0; done = 0; stall_bad = 0;
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_addr = a; acc_wdata = d;
    for (int c = 0; c < 40 && !done; c++) begin
      #1;
      if (acc_ready) begin done = 1; got_rd = acc_rdata; end
      else if (req_valid) begin
        if (nreq < 4) begin rq_t[nreq] = req_type; rq_a[nreq] = req_addr; rq_d[nreq] = req_data; end
        nreq++;
        for (int k = 0; k < dly; k++) begin
          @(negedge clk); #1;
          if (!req_valid || acc_ready || req_type != rq_t[0] || req_addr != rq_a[0]) stall_bad = 1;
        end
        ack_shared = sh; ack_data = ad; req_ack = 1; #1;
        if (acc_ready) begin done = 1; got_rd = acc_rdata; end
      end
      @(posedge clk); #1;
      req_ack = 0;
      if (!done) @(negedge clk);
    end
    acc_valid = 0;
    chk(done, "R10 access completes", done, 1);
  endtask

  task automatic do_snoop(input logic t, input logic [7:0] a);
    @(negedge clk);
    snp_valid = 1; snp_type = t; snp_addr = a;
    #1;
    s_rdy = snp_ready; s_hit = snp_hit; s_dirty = snp_dirty; s_data = snp_data;
    @(posedge clk); #1;
    snp_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(req_valid == 0, "R11 req_valid after reset", req_valid, 0);
    do_snoop(0, 8'h05);
    chk(s_rdy == 1 && s_hit == 0, "R11 snoop miss after reset", s_hit, 0);
  endtask

  task automatic t_read_miss_and_hits;
    do_access(0, 8'h05, 0, 0, 16'hAAAA, 0);
    chk(nreq == 1 && rq_t[0] == 1 && rq_a[0] == 8'h05, "R4 fill request", rq_t[0], 1);
    chk(got_rd == 16'hAAAA, "R4 read data from fill", got_rd, 16'hAAAA);
    do_access(1, 8'h05, 16'h1111, 0, 0, 0);
    chk(nreq == 0, "R1 write hit on E silent", nreq, 0);
    do_access(0, 8'h05, 0, 0, 0, 0);
    chk(nreq == 0 && got_rd == 16'h1111, "R1 read hit", got_rd, 16'h1111);
    do_snoop(0, 8'h05);
    chk(s_hit && s_dirty && s_data == 16'h1111, "R8 fill snoop on M", s_data, 16'h1111);
  endtask

  task automatic t_upgrade;
    do_access(1, 8'h05, 16'h2222, 0, 0, 3);
    chk(nreq == 1 && rq_t[0] == 0 && rq_a[0] == 8'h05, "R3 invalidate request", rq_t[0], 0);
    chk(!stall_bad, "R10 request held and access stalled", stall_bad, 0);
    do_snoop(0, 8'h05);
    chk(s_hit && s_dirty && s_data == 16'h2222, "R3 line Modified after upgrade", s_dirty, 1);
  endtask

  task automatic t_evict;
    do_access(1, 8'h05, 16'h3333, 0, 0, 0);
    do_access(0, 8'h09, 0, 1, 16'hBBBB, 0);
    chk(nreq == 2, "R6 two requests", nreq, 2);
    chk(rq_t[0] == 3 && rq_a[0] == 8'h05 && rq_d[0] == 16'h3333, "R6 write-back first", rq_d[0], 16'h3333);
    chk(rq_t[1] == 1 && rq_a[1] == 8'h09, "R6 fill after write-back", rq_t[1], 1);
    chk(got_rd == 16'hBBBB, "R4 read data after evict", got_rd, 16'hBBBB);
    do_snoop(0, 8'h05);
    chk(!s_hit, "R6 victim gone", s_hit, 0);
    do_snoop(0, 8'h09);
    chk(s_hit && !s_dirty && s_data == 16'hBBBB, "R4 shared fill not dirty", s_dirty, 0);
    do_access(1, 8'h09, 16'h9999, 0, 0, 0);
    chk(nreq == 1 && rq_t[0] == 0, "R4 ack_shared gives Shared", rq_t[0], 0);
  endtask

  task automatic t_write_miss;
    do_access(1, 8'h22, 16'h4444, 0, 0, 0);
    chk(nreq == 1 && rq_t[0] == 2 && rq_a[0] == 8'h22, "R5 fill-invalidate request", rq_t[0], 2);
    do_snoop(1, 8'h22);
    chk(s_rdy && s_hit && s_dirty && s_data == 16'h4444, "R7 invalidate snoop returns dirty", s_data, 16'h4444);
    do_snoop(0, 8'h22);
    chk(!s_hit, "R7 line invalid after snoop", s_hit, 0);
  endtask

  task automatic t_fill_snoop_on_e;
    do_access(0, 8'h13, 0, 0, 16'h5555, 0);
    do_snoop(0, 8'h13);
    chk(s_hit && !s_dirty && s_data == 16'h5555, "R8 fill snoop on E", s_data, 16'h5555);
    do_access(1, 8'h13, 16'h5A5A, 0, 0, 0);
    chk(nreq == 1 && rq_t[0] == 0, "R8 line demoted to Shared", rq_t[0], 0);
  endtask

  task automatic t_sleep;
    logic bad;
    bad = 0;
    @(negedge clk);
    light_sleep = 1; acc_valid = 1; acc_write = 1; acc_addr = 8'h30; acc_wdata = 16'h7777;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1;
      if (req_valid || acc_ready) bad = 1;
    end
    chk(!bad, "R9 no request or completion in sleep", bad, 0);
    do_snoop(1, 8'h13);
    chk(s_rdy && s_hit && s_dirty && s_data == 16'h5A5A, "R9 snoop served in sleep", s_data, 16'h5A5A);
    #1;
    chk(!req_valid, "R9 still quiet after snoop", req_valid, 0);
    light_sleep = 0;
    acc_valid = 0;
    do_access(1, 8'h30, 16'h7777, 0, 0, 0);
    chk(nreq == 1 && rq_t[0] == 2 && rq_a[0] == 8'h30, "R9 access resumes after wake", rq_t[0], 2);
  endtask

  task automatic t_write_through;
    wt_mode = 1;
    do_access(0, 8'h06, 0, 0, 16'h6060, 0);
    do_access(1, 8'h06, 16'h6666, 0, 0, 0);
    chk(nreq == 0, "R2 write hit on E silent", nreq, 0);
    do_snoop(0, 8'h06);
    chk(s_hit && !s_dirty && s_data == 16'h6666, "R2 no Modified after write hit", s_dirty, 0);
    do_access(1, 8'h06, 16'h6767, 0, 0, 0);
    chk(nreq == 1 && rq_t[0] == 0, "R2 upgrade request", rq_t[0], 0);
    do_snoop(0, 8'h06);
    chk(s_hit && !s_dirty && s_data == 16'h6767, "R2 no Modified after upgrade", s_dirty, 0);
    do_access(1, 8'h0B, 16'h6868, 0, 0, 0);
    chk(nreq == 1 && rq_t[0] == 2, "R2 write miss request", rq_t[0], 2);
    do_snoop(1, 8'h0B);
    chk(s_hit && !s_dirty && s_data == 16'h6868, "R2 no Modified after write miss", s_dirty, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_read_miss_and_hits();
    t_upgrade();
    t_evict();
    t_write_miss();
    t_fill_snoop_on_e();
    t_sleep();
    t_write_through();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule